// File: doc/BRIEF.md
# Outstanding Miss Tracker with Register Scoreboard

This block lets an in-order pipeline keep issuing after a load misses the cache. Each tracking entry owns one whole memory line. It holds the line address and, for every word of that line, the destination register that waits for the word, if there is one. A load miss to a line that is not being tracked claims a free entry and sends one line request to memory. A load miss to a line that is already tracked joins that entry and sends nothing. Either way the load leaves the pipeline at once, and its destination register is marked empty in a per-register full/empty scoreboard.

The decode stage presents two source register numbers each cycle and holds any instruction whose sources are still empty. When memory returns the line, the block presents every waiting register together with its word in the same cycle. It marks those registers full and frees the entry. When a miss cannot be taken, the block raises a stall and records nothing, and the pipeline presents the same miss again later.

Top module: `mshr_file`

## Requirements
- R1: After reset no entry is in use, every register reads as full (decodeStall low for any sources), memReqValid is low with no miss presented, and no writeback lane is valid.
- R2: A miss to an untracked line, with an entry free, drives memReqValid high in the same cycle with memReqAddr equal to the line and memReqId equal to the lowest-numbered free entry. The entry is taken only if memReqReady is high in that cycle. Otherwise missStall is high and nothing is recorded.
- R3: A miss to a tracked line whose addressed word has no waiter joins that entry: no stall and no memory request.
- R4: A miss to a tracked line whose addressed word already has a waiter stalls and records nothing.
- R5: A miss to an untracked line while all entries are in use stalls and issues no memory request.
- R6: An accepted miss marks its destination register empty from the next cycle. decodeStall is high while srcA or srcB names an empty register.
- R7: A refill for an entry in use drives, in the same cycle, wbValid[w], wbReg slice w (bits w*5 up) and wbData slice w (bits w*32 up, taken from refillData word w) for each word w that has a waiter. From the next cycle those registers read full and the entry is free.
- R8: A refill naming an entry not in use produces no writeback and changes no register.
- R9: A miss to the line of the entry being refilled in that same cycle stalls and records nothing.
- R10: If an accepted miss marks a register empty in the same cycle that a refill writes that register back, the register ends empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| missValid | input | 1 | A load miss is presented |
| missLine | input | 26 | Line address of the miss |
| missWord | input | 3 | Word index within the line |
| missDest | input | 5 | Destination register of the load |
| missStall | output | 1 | Miss not taken this cycle; present it again |
| memReqValid | output | 1 | Line request to memory |
| memReqAddr | output | 26 | Line address requested |
| memReqId | output | 2 | Entry that the refill will name |
| memReqReady | input | 1 | Memory accepts the request |
| refillValid | input | 1 | A line returns from memory |
| refillId | input | 2 | Entry the returning line belongs to |
| refillData | input | 256 | Returned line, word w at bits w*32 |
| wbValid | output | 8 | Per-word register writeback strobe |
| wbReg | output | 40 | Per-word destination register |
| wbData | output | 256 | Per-word writeback data |
| srcA | input | 5 | First decode source register |
| srcB | input | 5 | Second decode source register |
| decodeStall | output | 1 | A source register is still empty |

## Verification
A lost waiter shows up as a missing writeback at the refill cycle, and the register it left behind stays empty, so decodeStall remains high for that register from then on. A duplicated or stale entry shows up as a merge that stalls or requests wrongly in the cycle the miss is presented, or as a writeback when an idle entry is refilled. A scoreboard bit set wrongly is seen one cycle after the miss or refill that should have changed it, through decodeStall. The bench keeps its own model of the entries and registers, predicts every writeback lane, and probes the scoreboard after each step.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  localparam int ENTRIES  = 4;
  localparam int WORDS    = 8;
  localparam int NUM_REGS = 32;
  localparam int LINE_W   = 26;
  localparam int DATA_W   = 32;
  localparam int IDX_W    = $clog2(ENTRIES);
  localparam int WIDX_W   = $clog2(WORDS);
  localparam int REG_W    = $clog2(NUM_REGS);

  typedef struct packed {
    logic              alloc;
    logic              merge;
    logic [IDX_W-1:0]  tgt;
    logic [WIDX_W-1:0] word;
    logic [REG_W-1:0]  dest;
    logic [LINE_W-1:0] line;
    logic              freeEn;
    logic [IDX_W-1:0]  relIdx;
  } mshrStrobe_t;
endpackage

// File: rtl/mshr_ctrl.sv
module mshr_ctrl
  import mshr_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             missValid,
  input  logic [LINE_W-1:0]                missLine,
  input  logic [WIDX_W-1:0]                missWord,
  input  logic [REG_W-1:0]                 missDest,
  input  logic                             memReqReady,
  input  logic                             refillValid,
  input  logic [IDX_W-1:0]                 refillId,
  input  logic [ENTRIES-1:0]               entryValid,
  input  logic [ENTRIES-1:0][LINE_W-1:0]   entryLine,
  input  logic [ENTRIES-1:0][WORDS-1:0]    slotBusy,
  output logic                             missStall,
  output logic                             memReqValid,
  output logic [LINE_W-1:0]                memReqAddr,
  output logic [IDX_W-1:0]                 memReqId,
  output mshrStrobe_t                      strb
);
  logic [ENTRIES-1:0] lineHit;
  logic               anyHit, anyFree, refillLive, mergeOk, needNew;
  logic [IDX_W-1:0]   hitIdx, freeIdx;

  genvar gi;
  generate
    for (gi = 0; gi < ENTRIES; gi++) begin : g_cmp
      assign lineHit[gi] = entryValid[gi] && (entryLine[gi] == missLine);
    end
  endgenerate

  // Lowest-numbered free entry and the (unique) matching entry.
  always_comb begin
    freeIdx = '0;
    anyFree = 1'b0;
    hitIdx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!entryValid[i]) begin
        freeIdx = IDX_W'(i);
        anyFree = 1'b1;
      end
      if (lineHit[i]) hitIdx = IDX_W'(i);
    end
  end

  assign anyHit     = |lineHit;
  assign refillLive = refillValid && entryValid[refillId];
  assign mergeOk    = missValid && anyHit && !slotBusy[hitIdx][missWord]
                      && !(refillLive && (refillId == hitIdx));
  assign needNew    = missValid && !anyHit && anyFree;

  assign memReqValid = needNew;
  assign memReqAddr  = missLine;
  assign memReqId    = freeIdx;

  always_comb begin
    strb        = '0;
    strb.alloc  = needNew && memReqReady;
    strb.merge  = mergeOk;
    strb.tgt    = needNew ? freeIdx : hitIdx;
    strb.word   = missWord;
    strb.dest   = missDest;
    strb.line   = missLine;
    strb.freeEn = refillLive;
    strb.relIdx = refillId;
  end

  assign missStall = missValid && !(strb.alloc || strb.merge);

  // R2
  alloc_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.alloc |=> entryValid[$past(memReqId)]);

  // R5
  full_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&entryValid) |-> !memReqValid);
endmodule

// File: rtl/mshr_dp.sv
module mshr_dp
  import mshr_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  mshrStrobe_t                      strb,
  input  logic                             refillValid,
  input  logic [IDX_W-1:0]                 refillId,
  input  logic [WORDS*DATA_W-1:0]          refillData,
  input  logic [REG_W-1:0]                 srcA,
  input  logic [REG_W-1:0]                 srcB,
  output logic [ENTRIES-1:0]               entryValid,
  output logic [ENTRIES-1:0][LINE_W-1:0]   entryLine,
  output logic [ENTRIES-1:0][WORDS-1:0]    slotBusy,
  output logic [WORDS-1:0]                 wbValid,
  output logic [WORDS*REG_W-1:0]           wbReg,
  output logic [WORDS*DATA_W-1:0]          wbData,
  output logic                             decodeStall
);
  logic [ENTRIES-1:0][WORDS-1:0][REG_W-1:0] waitReg;
  logic [NUM_REGS-1:0]                      regFull, regFullNxt;

  // Entry storage: release, allocate and join never hit the same entry.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entryValid <= '0;
      entryLine  <= '0;
      slotBusy   <= '0;
      waitReg    <= '0;
    end else begin
      if (strb.freeEn) begin
        entryValid[strb.relIdx] <= 1'b0;
        slotBusy[strb.relIdx]   <= '0;
      end
      if (strb.alloc) begin
        entryValid[strb.tgt]          <= 1'b1;
        entryLine[strb.tgt]           <= strb.line;
        slotBusy[strb.tgt]            <= WORDS'(1) << strb.word;
        waitReg[strb.tgt][strb.word]  <= strb.dest;
      end else if (strb.merge) begin
        slotBusy[strb.tgt][strb.word] <= 1'b1;
        waitReg[strb.tgt][strb.word]  <= strb.dest;
      end
    end
  end

  // Scoreboard: a new miss clearing a register wins over a writeback.
  always_comb begin
    regFullNxt = regFull;
    if (strb.freeEn) begin
      for (int w = 0; w < WORDS; w++)
        if (slotBusy[strb.relIdx][w]) regFullNxt[waitReg[strb.relIdx][w]] = 1'b1;
    end
    if (strb.alloc || strb.merge) regFullNxt[strb.dest] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regFull <= '1;
    else       regFull <= regFullNxt;
  end

  assign decodeStall = !regFull[srcA] || !regFull[srcB];

  genvar gw;
  generate
    for (gw = 0; gw < WORDS; gw++) begin : g_wb
      assign wbValid[gw] = strb.freeEn && slotBusy[strb.relIdx][gw];
      assign wbReg[gw*REG_W +: REG_W]    = waitReg[strb.relIdx][gw];
      assign wbData[gw*DATA_W +: DATA_W] = refillData[gw*DATA_W +: DATA_W];
    end
  endgenerate

  genvar ga, gb;
  generate
    for (ga = 0; ga < ENTRIES; ga++) begin : g_ua
      for (gb = ga + 1; gb < ENTRIES; gb++) begin : g_ub
        // R3
        one_entry_per_line_chk: assert property (@(posedge clk) disable iff (!rstN)
          !(entryValid[ga] && entryValid[gb] && (entryLine[ga] == entryLine[gb])));
      end
    end
  endgenerate

  // R6
  dest_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.alloc || strb.merge) |=> !regFull[$past(strb.dest)]);

  // R7
  entry_freed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refillValid && entryValid[refillId]) |=> !entryValid[$past(refillId)]);

  // R8
  idle_refill_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refillValid && !entryValid[refillId]) |-> (wbValid == '0));
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      missValid,
  input  logic [LINE_W-1:0]         missLine,
  input  logic [WIDX_W-1:0]         missWord,
  input  logic [REG_W-1:0]          missDest,
  output logic                      missStall,
  output logic                      memReqValid,
  output logic [LINE_W-1:0]         memReqAddr,
  output logic [IDX_W-1:0]          memReqId,
  input  logic                      memReqReady,
  input  logic                      refillValid,
  input  logic [IDX_W-1:0]          refillId,
  input  logic [WORDS*DATA_W-1:0]   refillData,
  output logic [WORDS-1:0]          wbValid,
  output logic [WORDS*REG_W-1:0]    wbReg,
  output logic [WORDS*DATA_W-1:0]   wbData,
  input  logic [REG_W-1:0]          srcA,
  input  logic [REG_W-1:0]          srcB,
  output logic                      decodeStall
);
  mshrStrobe_t                    strb;
  logic [ENTRIES-1:0]             entryValid;
  logic [ENTRIES-1:0][LINE_W-1:0] entryLine;
  logic [ENTRIES-1:0][WORDS-1:0]  slotBusy;

  mshr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .missValid(missValid), .missLine(missLine), .missWord(missWord), .missDest(missDest),
    .memReqReady(memReqReady), .refillValid(refillValid), .refillId(refillId),
    .entryValid(entryValid), .entryLine(entryLine), .slotBusy(slotBusy),
    .missStall(missStall), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memReqId(memReqId), .strb(strb)
  );

  mshr_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .refillValid(refillValid), .refillId(refillId), .refillData(refillData),
    .srcA(srcA), .srcB(srcB),
    .entryValid(entryValid), .entryLine(entryLine), .slotBusy(slotBusy),
    .wbValid(wbValid), .wbReg(wbReg), .wbData(wbData), .decodeStall(decodeStall)
  );
endmodule

// File: tb/mshr_file_tb.sv
module mshr_file_tb;
  import mshr_pkg::*;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    missValid = 1'b0;
  logic [LINE_W-1:0]       missLine = '0;
  logic [WIDX_W-1:0]       missWord = '0;
  logic [REG_W-1:0]        missDest = '0;
  logic                    missStall, memReqValid, decodeStall;
  logic [LINE_W-1:0]       memReqAddr;
  logic [IDX_W-1:0]        memReqId;
  logic                    memReqReady = 1'b0;
  logic                    refillValid = 1'b0;
  logic [IDX_W-1:0]        refillId = '0;
  logic [WORDS*DATA_W-1:0] refillData = '0;
  logic [WORDS-1:0]        wbValid;
  logic [WORDS*REG_W-1:0]  wbReg;
  logic [WORDS*DATA_W-1:0] wbData;
  logic [REG_W-1:0]        srcA = '0, srcB = '0;

  always #2.5 clk = ~clk;

  mshr_file u_dut (.*);

  typedef struct packed { logic [REG_W-1:0] r; logic [DATA_W-1:0] d; } wb_t;
  wb_t expQ[$];
  int  vectors = 0, fails = 0;
  bit  done = 1'b0;

  bit  mValid [ENTRIES];
  int  mLine  [ENTRIES];
  bit  mWV    [ENTRIES][WORDS];
  int  mWR    [ENTRIES][WORDS];

  task automatic chk(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input int id, input int w);
    return DATA_W'(32'hA000_0000 | (id << 8) | w);
  endfunction

  // Monitor: pops expected writebacks as lanes appear.
  initial forever begin
    @(negedge clk); #1;
    for (int w = 0; w < WORDS; w++) begin
      if (wbValid[w]) begin
        vectors++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R7: unexpected writeback lane %0d actual reg %0d expected none", w, wbReg[w*REG_W +: REG_W]);
        end else begin
          wb_t e, a;
          e = expQ.pop_front();
          a.r = wbReg[w*REG_W +: REG_W];
          a.d = wbData[w*DATA_W +: DATA_W];
          if (a != e) begin
            fails++;
            $display("FAIL R7: lane %0d actual %0h expected %0h", w, a, e);
          end
        end
      end
    end
  end

  task automatic step(input bit doMiss, input int line, input int word, input int dest,
                      input bit rdy, input bit doRef, input int refId,
                      input bit expStall, input bit expReq, input int expId, input string tag);
    int freeLow;
    int hit;
    @(negedge clk);
    missValid   = doMiss;
    missLine    = LINE_W'(line);
    missWord    = WIDX_W'(word);
    missDest    = REG_W'(dest);
    memReqReady = rdy;
    refillValid = doRef;
    refillId    = IDX_W'(refId);
    for (int w = 0; w < WORDS; w++) refillData[w*DATA_W +: DATA_W] = pat(refId, w);
    if (doRef && mValid[refId])
      for (int w = 0; w < WORDS; w++)
        if (mWV[refId][w]) expQ.push_back({REG_W'(mWR[refId][w]), pat(refId, w)});
    #1;
    chk({tag, " stall"}, missStall, expStall);
    chk({tag, " req"}, memReqValid, expReq);
    if (expReq) begin
      chk({tag, " reqId"}, memReqId, expId);
      chk({tag, " reqAddr"}, memReqAddr, line);
    end
    freeLow = -1;
    hit = -1;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!mValid[i]) freeLow = i;
      if (mValid[i] && mLine[i] == line) hit = i;
    end
    if (doMiss && !expStall) begin
      if (hit >= 0) begin
        mWV[hit][word] = 1'b1; mWR[hit][word] = dest;
      end else begin
        mValid[freeLow] = 1'b1; mLine[freeLow] = line;
        for (int w = 0; w < WORDS; w++) mWV[freeLow][w] = 1'b0;
        mWV[freeLow][word] = 1'b1; mWR[freeLow][word] = dest;
      end
    end
    if (doRef && mValid[refId] && !(doMiss && !expStall && hit < 0 && freeLow == refId)) begin
      mValid[refId] = 1'b0;
      for (int w = 0; w < WORDS; w++) mWV[refId][w] = 1'b0;
    end
    @(posedge clk); #1;
    missValid = 1'b0; refillValid = 1'b0; memReqReady = 1'b0;
  endtask

  task automatic probe(input int a, input int b, input bit exp, input string tag);
    @(negedge clk);
    srcA = REG_W'(a); srcB = REG_W'(b);
    #1;
    chk({tag, " decodeStall"}, decodeStall, exp);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    if (!done) $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) mValid[i] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    probe(0, 31, 1'b0, "R1");
    probe(5, 12, 1'b0, "R1");
    chk("R1 memReqValid", memReqValid, 0);
    chk("R1 wbValid", wbValid, 0);
    // R2 new line, memory not ready: stall, nothing recorded
    step(1, 'h100, 2, 5, 0, 0, 0, 1, 1, 0, "R2");
    probe(5, 0, 1'b0, "R2");
    // R2 accepted into entry 0; R6 register 5 empty
    step(1, 'h100, 2, 5, 1, 0, 0, 0, 1, 0, "R2");
    probe(5, 0, 1'b1, "R6");
    probe(0, 5, 1'b1, "R6");
    // R3 join on another word
    step(1, 'h100, 5, 7, 1, 0, 0, 0, 0, 0, "R3");
    probe(7, 7, 1'b1, "R6");
    // R4 same word already waiting
    step(1, 'h100, 5, 9, 1, 0, 0, 1, 0, 0, "R4");
    probe(9, 0, 1'b0, "R4");
    // R2 further lines take entries 1..3
    step(1, 'h200, 0, 10, 1, 0, 0, 0, 1, 1, "R2");
    step(1, 'h300, 7, 11, 1, 0, 0, 0, 1, 2, "R2");
    step(1, 'h400, 3, 12, 1, 0, 0, 0, 1, 3, "R2");
    // R5 all busy
    step(1, 'h500, 0, 14, 1, 0, 0, 1, 0, 0, "R5");
    probe(14, 0, 1'b0, "R5");
    // R9 miss to the line being refilled; R7 writeback of entry 0
    step(1, 'h100, 1, 13, 1, 1, 0, 1, 0, 0, "R9");
    probe(13, 0, 1'b0, "R9");
    probe(5, 7, 1'b0, "R7");
    // R8 refill of idle entry 0
    @(negedge clk);
    refillValid = 1'b1; refillId = '0;
    #1;
    chk("R8 wbValid", wbValid, 0);
    @(posedge clk); #1;
    refillValid = 1'b0;
    probe(5, 7, 1'b0, "R8");
    // R10 register 10 cleared by a new miss while its old line returns
    step(1, 'h600, 3, 10, 1, 1, 1, 0, 1, 0, "R10");
    probe(10, 0, 1'b1, "R10");
    // drain remaining entries
    step(0, 0, 0, 0, 0, 1, 2, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 1, 3, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R7");
    probe(10, 11, 1'b0, "R7");
    probe(12, 0, 1'b0, "R7");
    // R2 lowest free entry after drain is 0 again
    step(1, 'h700, 4, 20, 1, 0, 0, 0, 1, 0, "R2");
    @(negedge clk); #2;
    chk("R7 pending writebacks", expQ.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule